// File: doc/BRIEF.md
# Dual-Channel Serial Sync Receiver with Alternating Bit Periods

This block recovers bytes from serial sync lines. It runs in the fast system clock domain and has two independent channels. Each channel passes its line through a two-flop synchronizer and watches for a falling edge, which marks the start bit. It then waits a programmed delay to reach the middle of that bit. After that it samples each later bit after a programmed period. Bits with even numbers and bits with odd numbers have their own period settings. Alternating a period of N and N+1 cycles gives an average divisor with half-cycle resolution, so the clock does not have to be a whole multiple of the baud rate.

The frame is idle high, then a low start bit (bit 0), then eight data bits least significant first (bits 1 to 8), then a high stop bit (bit 9). A start bit that reads high again at its mid-cell sample is treated as a glitch and dropped. A stop bit that reads low raises a framing error and no word is delivered. Each of the three timing settings per channel holds the wanted cycle count minus one.

Top module: `sync_rx_pair`

## Requirements
- R1: While reset is high and on the first cycle after it, `word_valid`, `frame_err` and `word_out` are all zero.
- R2: The line is synchronized by two flops. A high-to-low change at the synchronizer output starts a frame, but only while the channel is idle.
- R3: The start bit (bit 0) is sampled `start_cyc_m1`+1 cycles after the cycle in which the falling edge is detected.
- R4: After the channel samples bit k, the next sample comes `odd_cyc_m1`+1 cycles later if k is odd and `even_cyc_m1`+1 cycles later if k is even. The start bit counts as bit 0, which is even.
- R5: Bits 1 to 8 form the data word, least significant bit first. `word_out` carries bit 1 in position 0.
- R6: If the start bit reads high at its sample, the frame is dropped and the channel returns to idle without raising `word_valid` or `frame_err`.
- R7: If the stop bit (bit 9) reads high, `word_valid` is high for exactly one cycle, on the cycle after the stop sample. `word_out` then holds that word until the next valid word.
- R8: If the stop bit reads low, `frame_err` is high for exactly one cycle and `word_valid` stays low. `word_out` keeps its earlier value.
- R9: The two channels work independently. Each uses its own line and its own three timing settings. Channel c uses slice c of every packed port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | NCH | Serial line per channel, idle high |
| start_cyc_m1 | input | NCH*CNT_W | Per channel: cycles from edge detection to the start-bit sample, minus one |
| odd_cyc_m1 | input | NCH*CNT_W | Per channel: period after an odd-numbered bit, minus one |
| even_cyc_m1 | input | NCH*CNT_W | Per channel: period after an even-numbered bit, minus one |
| word_out | output | NCH*DATA_W | Last good word per channel |
| word_valid | output | NCH | One-cycle strobe for a new good word |
| frame_err | output | NCH | One-cycle strobe for a low stop bit |

## Verification
Frames with equal odd and even periods carrying 0xA5, 0x00 and 0xFF check the plain bit order and the all-equal data cases. Frames whose bit lengths alternate between 9 and 8 cycles, received with matching odd and even settings, show whether the periods are applied to the correct bit parity. A swap would move the samples toward the cell edges and, in the cycle-exact comparison, put the strobe in a different cycle. A two-cycle low glitch, a frame with a low stop bit, a minimum two-cycle start delay and traffic on both lines at once separate the drop path, the error path, the start-delay timing and channel isolation.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_t;
endpackage

// File: rtl/sync_rx_edge.sv
module sync_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_sync,
  output logic fall
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= line_raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign line_sync = sync_q;
  assign fall      = hist_q & ~sync_q;
endmodule

// File: rtl/sync_rx_chan.sv
module sync_rx_chan #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_raw,
  input  logic [CNT_W-1:0]  start_m1,
  input  logic [CNT_W-1:0]  odd_m1,
  input  logic [CNT_W-1:0]  even_m1,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              ferr_q
);
  import sync_rx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);

  logic              line_s, fall_s;
  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;

  sync_rx_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .line_raw (line_raw),
    .line_sync(line_s),
    .fall     (fall_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (fall_s) begin
            state <= RX_RUN;
            cnt   <= start_m1;
            idx   <= '0;
          end
        end
        RX_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (idx == '0 && line_s) begin
            state <= RX_IDLE;
          end else if (idx == STOP_IDX) begin
            if (line_s) begin
              data_q  <= shreg;
              valid_q <= 1'b1;
            end else begin
              ferr_q <= 1'b1;
            end
            state <= RX_IDLE;
          end else begin
            if (idx != '0) shreg <= {line_s, shreg[DATA_W-1:1]};
            cnt <= idx[0] ? odd_m1 : even_m1;
            idx <= idx + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sync_rx_pair.sv
module sync_rx_pair #(
  parameter int NCH    = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ser_in,
  input  logic [NCH*CNT_W-1:0]  start_cyc_m1,
  input  logic [NCH*CNT_W-1:0]  odd_cyc_m1,
  input  logic [NCH*CNT_W-1:0]  even_cyc_m1,
  output logic [NCH*DATA_W-1:0] word_out,
  output logic [NCH-1:0]        word_valid,
  output logic [NCH-1:0]        frame_err
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sync_rx_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .line_raw(ser_in[c]),
      .start_m1(start_cyc_m1[c*CNT_W +: CNT_W]),
      .odd_m1  (odd_cyc_m1[c*CNT_W +: CNT_W]),
      .even_m1 (even_cyc_m1[c*CNT_W +: CNT_W]),
      .data_q  (word_out[c*DATA_W +: DATA_W]),
      .valid_q (word_valid[c]),
      .ferr_q  (frame_err[c])
    );
  end
endmodule

// File: rtl/sync_rx_pair_chk.sv
module sync_rx_pair_chk #(
  parameter int NCH    = 2,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH*DATA_W-1:0] word_out,
  input logic [NCH-1:0]        word_valid,
  input logic [NCH-1:0]        frame_err
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      word_valid[c] |=> !word_valid[c]); // R7
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      frame_err[c] |=> !frame_err[c]); // R8
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      !(frame_err[c] && word_valid[c])); // R8
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
      !word_valid[c] |-> $stable(word_out[c*DATA_W +: DATA_W])); // R7
  end
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (word_valid == '0 && frame_err == '0 && word_out == '0)); // R1
endmodule

bind sync_rx_pair sync_rx_pair_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_out  (word_out),
  .word_valid(word_valid),
  .frame_err (frame_err)
);

// File: tb/test_sync_rx_pair.sv
module test_sync_rx_pair;
  localparam int NCH = 2, DW = 8, CW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] rx = '1;
  logic [CW-1:0] st_r [NCH], od_r [NCH], ev_r [NCH];
  logic [NCH*CW-1:0] st_bus, od_bus, ev_bus;
  logic [NCH*DW-1:0] wout;
  logic [NCH-1:0] wval, ferr;

  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      st_bus[c*CW +: CW] = st_r[c];
      od_bus[c*CW +: CW] = od_r[c];
      ev_bus[c*CW +: CW] = ev_r[c];
    end
  end

  sync_rx_pair #(.NCH(NCH), .DATA_W(DW), .CNT_W(CW)) i_sync_rx_pair (
    .clk(clk), .rst(rst), .ser_in(rx),
    .start_cyc_m1(st_bus), .odd_cyc_m1(od_bus), .even_cyc_m1(ev_bus),
    .word_out(wout), .word_valid(wval), .frame_err(ferr));

  int vectors = 0, fails = 0;
  int nval [NCH], nerr [NCH];
  logic [DW-1:0] last_word [NCH];

  // behavioural reference model
  int m1 [NCH], m2 [NCH], m3 [NCH];
  int busy [NCH], wt [NCH], nb [NCH], acc [NCH];
  int e_val [NCH], e_err [NCH], e_dat [NCH];

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        m1[c] = 1; m2[c] = 1; m3[c] = 1; busy[c] = 0; wt[c] = 0; nb[c] = 0;
        acc[c] = 0; e_val[c] = 0; e_err[c] = 0; e_dat[c] = 0;
      end else begin
        e_val[c] = 0; e_err[c] = 0;
        if (busy[c] == 0) begin
          if (m3[c] == 1 && m2[c] == 0) begin
            busy[c] = 1; wt[c] = int'(st_r[c]); nb[c] = 0; acc[c] = 0;
          end
        end else if (wt[c] > 0) begin
          wt[c] = wt[c] - 1;
        end else if (nb[c] == 0) begin
          if (m2[c] == 1) busy[c] = 0;
          else begin wt[c] = int'(ev_r[c]); nb[c] = 1; end
        end else if (nb[c] <= DW) begin
          acc[c] = acc[c] + (m2[c] << (nb[c] - 1));
          wt[c] = (nb[c] % 2 == 1) ? int'(od_r[c]) : int'(ev_r[c]);
          nb[c] = nb[c] + 1;
        end else begin
          if (m2[c] == 1) begin e_val[c] = 1; e_dat[c] = acc[c]; end
          else e_err[c] = 1;
          busy[c] = 0;
        end
        m3[c] = m2[c]; m2[c] = m1[c]; m1[c] = int'(rx[c]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        chk(int'(wval[c]) == e_val[c], "R7 R3 R4 strobe timing", int'(wval[c]), e_val[c]);
        chk(int'(ferr[c]) == e_err[c], "R8 error strobe", int'(ferr[c]), e_err[c]);
        if (wval[c]) begin
          chk(int'(wout[c*DW +: DW]) == e_dat[c], "R5 word", int'(wout[c*DW +: DW]), e_dat[c]);
          nval[c]++;
          last_word[c] = wout[c*DW +: DW];
        end
        if (ferr[c]) nerr[c]++;
      end
    end
  end

  task automatic send(input int c, input logic [DW-1:0] b, input int le, input int lo, input bit stop);
    for (int k = 0; k < DW + 2; k++) begin
      @(negedge clk);
      rx[c] = (k == 0) ? 1'b0 : (k == DW + 1) ? stop : b[k-1];
      repeat (((k % 2) == 0 ? le : lo) - 1) @(negedge clk);
    end
    @(negedge clk); rx[c] = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic cfg(input int c, input int s, input int o, input int e);
    st_r[c] = CW'(s); od_r[c] = CW'(o); ev_r[c] = CW'(e);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v0, e0;
    for (int c = 0; c < NCH; c++) begin nval[c] = 0; nerr[c] = 0; last_word[c] = '0; end
    cfg(0, 3, 7, 7); cfg(1, 3, 7, 8);
    repeat (3) @(negedge clk);
    chk(wval == '0 && ferr == '0 && wout == '0, "R1 reset outputs", int'(wout), 0);
    @(negedge clk); rst = 1'b0;
    chk(wval == '0 && ferr == '0 && wout == '0, "R1 after reset", int'(wout), 0);

    // R5: plain frames, equal periods
    send(0, 8'hA5, 8, 8, 1'b1);
    chk(last_word[0] == 8'hA5 && nval[0] == 1, "R5 byte A5", int'(last_word[0]), 'hA5);
    send(0, 8'h00, 8, 8, 1'b1);
    chk(last_word[0] == 8'h00 && nval[0] == 2, "R5 byte 00", int'(last_word[0]), 0);
    send(0, 8'hFF, 8, 8, 1'b1);
    chk(last_word[0] == 8'hFF && nval[0] == 3, "R5 byte FF", int'(last_word[0]), 'hFF);

    // R4: bit cells alternate 9 (even) and 8 (odd) cycles
    send(1, 8'h3C, 9, 8, 1'b1);
    chk(last_word[1] == 8'h3C, "R4 fractional period", int'(last_word[1]), 'h3C);
    chk(nval[0] == 3, "R9 other channel quiet", nval[0], 3);

    // R9: both channels at once with different data
    fork
      send(0, 8'h81, 8, 8, 1'b1);
      send(1, 8'h5E, 9, 8, 1'b1);
    join
    chk(last_word[0] == 8'h81, "R9 channel 0 word", int'(last_word[0]), 'h81);
    chk(last_word[1] == 8'h5E, "R9 channel 1 word", int'(last_word[1]), 'h5E);

    // R6: short glitch is dropped
    v0 = nval[0]; e0 = nerr[0];
    @(negedge clk); rx[0] = 1'b0;
    repeat (2) @(negedge clk); rx[0] = 1'b1;
    repeat (40) @(negedge clk);
    chk(nval[0] == v0 && nerr[0] == e0, "R6 glitch dropped", nval[0] + nerr[0], v0 + e0);
    chk(wout[DW-1:0] == 8'h81, "R6 word unchanged", int'(wout[DW-1:0]), 'h81);
    send(0, 8'h6B, 8, 8, 1'b1);
    chk(last_word[0] == 8'h6B, "R2 R6 receive after glitch", int'(last_word[0]), 'h6B);

    // R8: low stop bit
    v0 = nval[0]; e0 = nerr[0];
    send(0, 8'h12, 8, 8, 1'b0);
    chk(nerr[0] == e0 + 1, "R8 error raised", nerr[0], e0 + 1);
    chk(nval[0] == v0, "R8 no valid", nval[0], v0);
    chk(wout[DW-1:0] == 8'h6B, "R8 word held", int'(wout[DW-1:0]), 'h6B);

    // R3: minimum start delay of two cycles, short bits
    cfg(0, 1, 3, 3);
    repeat (2) @(negedge clk);
    send(0, 8'hC3, 4, 4, 1'b1);
    chk(last_word[0] == 8'hC3, "R3 short start delay", int'(last_word[0]), 'hC3);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule